// File: doc/BRIEF.md
# Halted-Hart Park Window Controller

This block is the small memory region that halted harts run their wait loop from. A hart that has stopped announces itself by storing its hart number to a fixed word. It then keeps reading a flag word to learn whether the debug controller wants it to run the scratch program or to leave debug mode. The controller owns the flags. A separate, fixed flag byte belongs to each hart, so a single halted hart can be steered without disturbing the others.

The debug controller starts a command on one hart with a one-cycle execute request and requests a resume in the same way. It watches `busy` and a sticky error code. The hart acknowledges each step by storing its number to a dedicated acknowledgement word: one when it starts the program, one when it is back in the loop, and one when it leaves debug mode. It reports a fault by a store to an exception word. The scratch program words and the data words form one contiguous window ending at offset 0x400 + data. Both sides can reach the window: the hart over the bus and the controller over its own word port. When the resume flag is seen, the hart runs `dret` (0x7b200073) from its own loop code.

Top module: `dbg_park_ctrl`

## Requirements
- R1: A bus write of value N to offset 0x100, with N below NHARTS, sets `halted[N]` from the next cycle. A value of NHARTS or more changes no halted bit.
- R2: A read of offset 0x300 returns one byte per hart (byte i for hart i), with bit 0 set while the hart's run flag is up and bit 1 set while its resume flag is up. The run flag and the resume flag of a hart are never both set.
- R3: An execute request is accepted when `busy` is low, the target hart is halted and has no resume pending. It then raises `busy` and the target's run flag. A write of the hart number to offset 0x104 drops that run flag.
- R4: After acceptance, `busy` stays high until the command's hart writes its number to offset 0x100. `busy` then reads 0 in the next cycle.
- R5: An execute request while `busy` is high is ignored. It sets `cmderr` to 1 (busy).
- R6: A write to offset 0x10C while `busy` is high sets `cmderr` to 3 (exception). The same write while idle has no effect. `cmderr` keeps its first nonzero value until a `cmderr_clr` pulse returns it to 0.
- R7: A resume request for a halted hart while idle raises that hart's resume flag. A write of its number to offset 0x108 clears both its halted bit and its resume flag. A resume request while busy is ignored and sets `cmderr` to 1. An execute request or resume request for a hart that is not halted sets `cmderr` to 4.
- R8: The NPROG program words occupy the word offsets just below 0x400, and the NDATA data words start at 0x400. Controller index k maps to byte offset 0x400 - 4*NPROG + 4*k. Hart writes and controller writes reach the same storage, and both sides read it back at once.
- R9: A controller write to the window while `busy` is high changes no word.
- R10: An execute request arriving in the same cycle as the hart's return write is judged against the `busy` value before that edge. It is rejected with `cmderr` = 1, and `busy` reads 0 afterwards.
- R11: After reset, `halted`, `busy`, `cmderr`, all flags and all window words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Hart bus access this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 12 | Byte offset inside the region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| exec_req | input | 1 | Start a command, one-cycle pulse |
| exec_hart | input | HW | Target hart of the command |
| resume_req | input | 1 | Request a resume, one-cycle pulse |
| resume_hart | input | HW | Target hart of the resume |
| cmderr_clr | input | 1 | Clear the error code |
| dm_we | input | 1 | Controller window write |
| dm_idx | input | IW | Controller window word index |
| dm_wdata | input | 32 | Controller window write data |
| dm_rdata | output | 32 | Controller window read data, same cycle |
| halted | output | NHARTS | Per-hart halted status |
| busy | output | 1 | A command is in flight |
| cmderr | output | 3 | Sticky error code |

## Verification
The hart's return write to offset 0x100, which ends a command, and a new execute request from the controller can land on the same clock edge. The bench sets up this collision by raising both in one cycle after the run acknowledgement. Per R10, the request must be rejected because it sees the old `busy`. The expected state after that edge is `busy` low with `cmderr` at 1. A resume request held off by a running command also raises the busy error, and the bench checks this.

// File: rtl/dbg_park_pkg.sv
package dbg_park_pkg;

    localparam logic [11:0] OFS_HALTED   = 12'h100;
    localparam logic [11:0] OFS_GOING    = 12'h104;
    localparam logic [11:0] OFS_RESUMING = 12'h108;
    localparam logic [11:0] OFS_EXCEPT   = 12'h10C;
    localparam logic [11:0] OFS_FLAGS    = 12'h300;
    localparam logic [11:0] OFS_DATA0    = 12'h400;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_BUSY    = 3'd1,
        ERR_EXCEPT  = 3'd3,
        ERR_HALTRES = 3'd4
    } cmderr_e;

    // decoded hart-side acknowledgement writes
    typedef struct packed {
        logic halted_wr;
        logic going_wr;
        logic resuming_wr;
        logic except_wr;
    } park_evt_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic [9:0] word_of(input logic [11:0] ofs);
        return ofs[11:2];
    endfunction

endpackage

// File: rtl/dbg_hart_flags.sv
module dbg_hart_flags #(
    parameter int NHARTS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NHARTS-1:0] halt_set,
    input  logic [NHARTS-1:0] go_set,
    input  logic [NHARTS-1:0] go_clr,
    input  logic [NHARTS-1:0] res_set,
    input  logic [NHARTS-1:0] res_ack,
    output logic [NHARTS-1:0] halted,
    output logic [NHARTS-1:0] go,
    output logic [NHARTS-1:0] resume
);

    for (genvar h = 0; h < NHARTS; h++) begin : g_hart
        always_ff @(posedge clk) begin
            if (rst) begin
                halted[h] <= 1'b0;
                go[h]     <= 1'b0;
                resume[h] <= 1'b0;
            end else begin
                if (res_ack[h])
                    halted[h] <= 1'b0;
                else if (halt_set[h])
                    halted[h] <= 1'b1;

                if (go_set[h])
                    go[h] <= 1'b1;
                else if (go_clr[h] || res_ack[h])
                    go[h] <= 1'b0;

                if (res_set[h])
                    resume[h] <= 1'b1;
                else if (res_ack[h])
                    resume[h] <= 1'b0;
            end
        end

        // R2: run and resume flags of one hart are exclusive
        a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
            !(go[h] && resume[h]));
    end

endmodule

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl
    import dbg_park_pkg::*;
#(
    parameter int NHARTS = 2,
    localparam int HW = idx_width(NHARTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_req,
    input  logic [HW-1:0]     exec_hart,
    input  logic              resume_req,
    input  logic [HW-1:0]     resume_hart,
    input  logic [NHARTS-1:0] halted,
    input  logic [NHARTS-1:0] resume_pend,
    input  logic              ret_wr,
    input  logic [HW-1:0]     ret_id,
    input  logic              except_wr,
    input  logic              cmderr_clr,
    output logic              busy,
    output cmderr_e           cmderr,
    output logic [NHARTS-1:0] go_set,
    output logic [NHARTS-1:0] done,
    output logic [NHARTS-1:0] res_set
);

    logic [HW-1:0] cmd_hart;
    logic          exec_ok, res_ok, exec_acc, res_acc, ret_hit;
    cmderr_e       err_new, err_base;

    always_comb begin
        exec_ok = (int'(exec_hart) < NHARTS) && halted[exec_hart] && !resume_pend[exec_hart];
        res_ok  = (int'(resume_hart) < NHARTS) && halted[resume_hart];
        ret_hit = ret_wr && busy && (ret_id == cmd_hart);
        exec_acc = exec_req && !busy && exec_ok;
        res_acc  = resume_req && !busy && !exec_acc && res_ok;

        if (except_wr && busy)
            err_new = ERR_EXCEPT;
        else if ((exec_req || resume_req) && busy)
            err_new = ERR_BUSY;
        else if (resume_req && exec_acc)
            err_new = ERR_BUSY;
        else if ((exec_req && !exec_ok) || (resume_req && !res_ok))
            err_new = ERR_HALTRES;
        else
            err_new = ERR_NONE;

        err_base = cmderr_clr ? ERR_NONE : cmderr;

        go_set  = '0;
        done    = '0;
        res_set = '0;
        if (exec_acc) go_set[exec_hart]   = 1'b1;
        if (ret_hit)  done[cmd_hart]      = 1'b1;
        if (res_acc)  res_set[resume_hart] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cmd_hart <= '0;
            cmderr   <= ERR_NONE;
        end else begin
            if (exec_acc) begin
                busy     <= 1'b1;
                cmd_hart <= exec_hart;
            end else if (ret_hit) begin
                busy <= 1'b0;
            end
            cmderr <= (err_base == ERR_NONE) ? err_new : err_base;
        end
    end

    // R4: busy only drops on the command hart's return write
    a_r4_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !ret_hit) |=> busy);

    // R5: a request during a command leaves the running command untouched
    a_r5_busy_rejects: assert property (@(posedge clk) disable iff (rst)
        (busy && exec_req && !ret_hit) |=> (busy && cmd_hart == $past(cmd_hart)));

    // R6: the error code is sticky until cleared
    a_r6_cmderr_sticky: assert property (@(posedge clk) disable iff (rst)
        (cmderr != ERR_NONE && !cmderr_clr) |=> (cmderr == $past(cmderr)));

endmodule

// File: rtl/dbg_win_mem.sv
module dbg_win_mem
    import dbg_park_pkg::*;
#(
    parameter int NPROG = 4,
    parameter int NDATA = 2,
    localparam int NW = NPROG + NDATA,
    localparam int IW = idx_width(NW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy,
    input  logic          hart_we,
    input  logic [IW-1:0] hart_idx,
    input  logic [31:0]   hart_wdata,
    output logic [31:0]   hart_rdata,
    input  logic          dm_we,
    input  logic [IW-1:0] dm_idx,
    input  logic [31:0]   dm_wdata,
    output logic [31:0]   dm_rdata
);

    logic [31:0] words [NW];

    for (genvar w = 0; w < NW; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[w] <= '0;
            else if (hart_we && int'(hart_idx) == w)
                words[w] <= hart_wdata;
            else if (dm_we && !busy && int'(dm_idx) == w)
                words[w] <= dm_wdata;
        end

        // R9: controller writes during a command reach no word
        a_r9_dm_blocked: assert property (@(posedge clk) disable iff (rst)
            (dm_we && busy && !(hart_we && int'(hart_idx) == w)) |=> $stable(words[w]));
    end

    always_comb begin
        hart_rdata = (int'(hart_idx) < NW) ? words[hart_idx] : '0;
        dm_rdata   = (int'(dm_idx) < NW) ? words[dm_idx] : '0;
    end

endmodule

// File: rtl/dbg_park_ctrl.sv
module dbg_park_ctrl
    import dbg_park_pkg::*;
#(
    parameter int NHARTS = 2,
    parameter int NPROG  = 4,
    parameter int NDATA  = 2,
    localparam int HW = idx_width(NHARTS),
    localparam int IW = idx_width(NPROG + NDATA)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              exec_req,
    input  logic [HW-1:0]     exec_hart,
    input  logic              resume_req,
    input  logic [HW-1:0]     resume_hart,
    input  logic              cmderr_clr,
    input  logic              dm_we,
    input  logic [IW-1:0]     dm_idx,
    input  logic [31:0]       dm_wdata,
    output logic [31:0]       dm_rdata,
    output logic [NHARTS-1:0] halted,
    output logic              busy,
    output logic [2:0]        cmderr
);

    localparam int NW    = NPROG + NDATA;
    localparam int WBASE = int'(word_of(OFS_DATA0)) - NPROG;
    localparam int WEND  = int'(word_of(OFS_DATA0)) + NDATA;

    park_evt_t         evt;
    logic [9:0]        widx, woff;
    logic              wr, id_ok, win_hit;
    logic [HW-1:0]     id;
    logic [IW-1:0]     win_idx;
    logic [31:0]       win_rdata, flag_word;
    logic [NHARTS-1:0] id_hot, halt_set, go_clr, res_ack;
    logic [NHARTS-1:0] go, resume, go_set, done, res_set;
    cmderr_e           cmderr_q;

    always_comb begin
        widx  = bus_addr[11:2];
        wr    = bus_req && bus_we;
        id    = bus_wdata[HW-1:0];
        id_ok = bus_wdata < 32'(NHARTS);
        evt.halted_wr   = wr && widx == word_of(OFS_HALTED);
        evt.going_wr    = wr && widx == word_of(OFS_GOING);
        evt.resuming_wr = wr && widx == word_of(OFS_RESUMING);
        evt.except_wr   = wr && widx == word_of(OFS_EXCEPT);
        win_hit = int'(widx) >= WBASE && int'(widx) < WEND;
        woff    = widx - 10'(WBASE);
        win_idx = woff[IW-1:0];
    end

    for (genvar h = 0; h < NHARTS; h++) begin : g_dec
        assign id_hot[h]   = id_ok && int'(id) == h;
        assign halt_set[h] = evt.halted_wr && id_hot[h];
        assign go_clr[h]   = (evt.going_wr && id_hot[h]) || done[h];
        assign res_ack[h]  = evt.resuming_wr && id_hot[h];
    end

    always_comb begin
        flag_word = '0;
        for (int h = 0; h < NHARTS; h++)
            flag_word[8*h +: 2] = {resume[h], go[h]};
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_req && !bus_we) begin
            if (widx == word_of(OFS_FLAGS))
                bus_rdata = flag_word;
            else if (win_hit)
                bus_rdata = win_rdata;
        end
    end

    dbg_hart_flags #(.NHARTS(NHARTS)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .halt_set (halt_set),
        .go_set   (go_set),
        .go_clr   (go_clr),
        .res_set  (res_set),
        .res_ack  (res_ack),
        .halted   (halted),
        .go       (go),
        .resume   (resume)
    );

    dbg_cmd_ctrl #(.NHARTS(NHARTS)) u_cmd (
        .clk         (clk),
        .rst         (rst),
        .exec_req    (exec_req),
        .exec_hart   (exec_hart),
        .resume_req  (resume_req),
        .resume_hart (resume_hart),
        .halted      (halted),
        .resume_pend (resume),
        .ret_wr      (evt.halted_wr && id_ok),
        .ret_id      (id),
        .except_wr   (evt.except_wr),
        .cmderr_clr  (cmderr_clr),
        .busy        (busy),
        .cmderr      (cmderr_q),
        .go_set      (go_set),
        .done        (done),
        .res_set     (res_set)
    );

    assign cmderr = cmderr_q;

    dbg_win_mem #(.NPROG(NPROG), .NDATA(NDATA)) u_win (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .hart_we    (wr && win_hit),
        .hart_idx   (win_idx),
        .hart_wdata (bus_wdata),
        .hart_rdata (win_rdata),
        .dm_we      (dm_we),
        .dm_idx     (dm_idx),
        .dm_wdata   (dm_wdata),
        .dm_rdata   (dm_rdata)
    );

    // R1: an in-range announce marks that hart halted
    a_r1_announce_marks: assert property (@(posedge clk) disable iff (rst)
        (evt.halted_wr && id_ok) |=> halted[$past(id)]);

    // R7: a resume acknowledgement leaves the hart running
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (evt.resuming_wr && id_ok) |=> !halted[$past(id)]);

endmodule

// File: tb/test_dbg_park_ctrl.sv
module test_dbg_park_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 0, bus_we = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        exec_req = 0, resume_req = 0, cmderr_clr = 0;
    logic [0:0]  exec_hart = '0, resume_hart = '0;
    logic        dm_we = 0;
    logic [2:0]  dm_idx = '0;
    logic [31:0] dm_wdata = '0;
    logic [31:0] dm_rdata;
    logic [1:0]  halted;
    logic        busy;
    logic [2:0]  cmderr;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    always #4 clk = ~clk;

    dbg_park_ctrl #(.NHARTS(2), .NPROG(4), .NDATA(2)) i_dbg_park_ctrl (
        .clk(clk), .rst(rst),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .exec_req(exec_req), .exec_hart(exec_hart),
        .resume_req(resume_req), .resume_hart(resume_hart),
        .cmderr_clr(cmderr_clr),
        .dm_we(dm_we), .dm_idx(dm_idx), .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
        .halted(halted), .busy(busy), .cmderr(cmderr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=%0d expected<20000", cyc);
            summary();
        end
    end

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        #1 bus_req = 0;
    endtask

    task automatic dm_wr(input int k, input logic [31:0] d);
        @(negedge clk);
        dm_we = 1; dm_idx = 3'(k); dm_wdata = d;
        @(negedge clk);
        dm_we = 0;
    endtask

    task automatic dm_rd(input int k, output logic [31:0] d);
        @(negedge clk);
        dm_idx = 3'(k);
        #1 d = dm_rdata;
    endtask

    task automatic exec(input int h);
        @(negedge clk);
        exec_req = 1; exec_hart = 1'(h);
        @(negedge clk);
        exec_req = 0;
    endtask

    task automatic resume(input int h);
        @(negedge clk);
        resume_req = 1; resume_hart = 1'(h);
        @(negedge clk);
        resume_req = 0;
    endtask

    task automatic clr_err();
        @(negedge clk);
        cmderr_clr = 1;
        @(negedge clk);
        cmderr_clr = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R11 halted", 32'(halted), 0);
        chk("R11 busy", 32'(busy), 0);
        chk("R11 cmderr", 32'(cmderr), 0);
        bus_rd(12'h300, d);
        chk("R11 flags", d, 0);
        dm_rd(5, d);
        chk("R11 window", d, 0);
    endtask

    task automatic t_announce();
        bus_wr(12'h100, 1);
        chk("R1 hart1 halted", 32'(halted), 2);
        bus_wr(12'h100, 3);
        chk("R1 out-of-range id ignored", 32'(halted), 2);
        bus_wr(12'h100, 0);
        chk("R1 hart0 halted", 32'(halted), 3);
    endtask

    task automatic t_window();
        logic [31:0] d;
        for (int k = 0; k < 6; k++) dm_wr(k, 32'hA000_0000 + 32'(k));
        bus_rd(12'h3F0, d);
        chk("R8 first program word", d, 32'hA000_0000);
        bus_rd(12'h3FC, d);
        chk("R8 last program word", d, 32'hA000_0003);
        bus_rd(12'h400, d);
        chk("R8 data0 at 0x400", d, 32'hA000_0004);
        bus_wr(12'h404, 32'h1234_5678);
        dm_rd(5, d);
        chk("R8 hart write seen by controller", d, 32'h1234_5678);
    endtask

    task automatic t_command();
        logic [31:0] d;
        exec(1);
        chk("R3 busy raised", 32'(busy), 1);
        bus_rd(12'h300, d);
        chk("R3 run flag hart1", d, 32'h0000_0100);
        bus_wr(12'h104, 1);
        bus_rd(12'h300, d);
        chk("R3 run flag dropped", d, 0);
        chk("R4 busy held after run ack", 32'(busy), 1);
        dm_wr(0, 32'hDEAD_BEEF);
        dm_rd(0, d);
        chk("R9 window unchanged while busy", d, 32'hA000_0000);
        exec(0);
        chk("R5 busy error", 32'(cmderr), 1);
        chk("R5 still busy", 32'(busy), 1);
        bus_wr(12'h10C, 0);
        chk("R6 first error kept", 32'(cmderr), 1);
        clr_err();
        chk("R6 cleared", 32'(cmderr), 0);
        bus_wr(12'h100, 1);
        chk("R4 busy drops on return", 32'(busy), 0);
    endtask

    task automatic t_exception();
        exec(0);
        bus_wr(12'h104, 0);
        bus_wr(12'h10C, 0);
        chk("R6 exception code", 32'(cmderr), 3);
        bus_wr(12'h100, 0);
        chk("R4 busy drops after exception", 32'(busy), 0);
        chk("R6 exception sticky", 32'(cmderr), 3);
        clr_err();
        bus_wr(12'h10C, 0);
        chk("R6 idle exception ignored", 32'(cmderr), 0);
    endtask

    task automatic t_resume();
        logic [31:0] d;
        exec(0);
        resume(1);
        chk("R7 resume while busy error", 32'(cmderr), 1);
        bus_rd(12'h300, d);
        chk("R7 resume while busy no flag", d, 32'h0000_0001);
        bus_wr(12'h104, 0);
        bus_wr(12'h100, 0);
        clr_err();
        resume(1);
        bus_rd(12'h300, d);
        chk("R2 resume flag hart1", d, 32'h0000_0200);
        bus_wr(12'h108, 1);
        chk("R7 halted cleared", 32'(halted), 1);
        bus_rd(12'h300, d);
        chk("R7 resume flag cleared", d, 0);
        exec(1);
        chk("R7 not halted error", 32'(cmderr), 4);
        chk("R7 not halted no busy", 32'(busy), 0);
        clr_err();
    endtask

    task automatic t_same_cycle();
        exec(0);
        bus_wr(12'h104, 0);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = 12'h100; bus_wdata = 0;
        exec_req = 1; exec_hart = 0;
        @(negedge clk);
        bus_req = 0; bus_we = 0; exec_req = 0;
        chk("R10 busy ends", 32'(busy), 0);
        chk("R10 late request rejected", 32'(cmderr), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_announce();
        t_window();
        t_command();
        t_exception();
        t_resume();
        t_same_cycle();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule